// File: doc/BRIEF.md
# Linked Command-List Sequencer with Suspend and Resume

The block walks a chain of command blocks kept in a word-addressed memory. Each block starts with a control/status word. The next word is a link to the following block, and the payload begins at the third word. For each block the sequencer reads the link word and passes the payload address to an external executor with a start/done handshake. It then read-modify-writes the status word to mark the block complete, with an OK bit taken from the executor's error flag. Finally it either follows the link or parks in a suspended state.

A host starts the walk with a head address and may later issue a resume. On resume the sequencer does not read the finished block's link again; it uses the pointer saved at completion. It re-reads only the finished block's status word. If software has cleared the suspend bit, the walk continues at the saved block. If the bit is still set, the sequencer drops straight back to suspended. Memory is reached through a single word-wide port with request/grant. Read data returns one cycle after the grant.

Top module: `cmd_list_unit`

## Requirements
- R1: After reset, state_o is 00, and mem_req_o and exec_start_o are low.
- R2: A start in idle or suspended causes a read of word A+1 for head address A. It is followed by a one-cycle exec_start_o pulse with exec_addr_o = A+2, and state_o reads 01 from the cycle after the start.
- R3: mem_req_o stays high with a stable address, write flag and write data until mem_gnt_i. Only one access is outstanding. Read data is taken in the cycle after the grant.
- R4: After exec_done_i, the block's word 0 is read and then written back. Bit 15 is set, bit 13 equals the inverse of exec_err_i, and every other bit is kept as read.
- R5: If bit 30 of the word read during write-back is clear, the sequencer next reads word 1 of the block whose address was in that block's word 1.
- R6: If that bit 30 is set, state_o becomes 10. No memory request or executor start is issued until a start or resume arrives.
- R7: A resume in suspended causes exactly one read, of word 0 of the last completed block. If its bit 30 is clear, the next access is a read of word 1 at the link address saved at completion. The completed block's word 1 is never read again.
- R8: If bit 30 is still set on the resume re-read, state_o returns to 10 and no executor start is issued.
- R9: A resume in idle or while active has no effect.
- R10: A start while active is ignored, and the list in progress continues unchanged.
- R11: state_o encodes idle 00, active 01 (also during a resume re-read) and suspended 10, and never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW | Head block address for start |
| resume_i | input | 1 | Resume pulse |
| state_o | output | 2 | 00 idle, 01 active, 10 suspended |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write flag of the request |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_gnt_i | input | 1 | Grant of the current request |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read grant |
| exec_start_o | output | 1 | One-cycle start to the executor |
| exec_addr_o | output | AW | Payload address of the current block |
| exec_done_i | input | 1 | Executor finished |
| exec_err_i | input | 1 | Executor error, sampled with exec_done_i |

## Verification
The state output follows a start or resume one clock later. A read's data is consumed one clock after its grant. exec_start_o rises the cycle after the link read data is taken. The write-back request appears the cycle after exec_done_i and lasts for a granted read plus a granted write, so its result is in memory one clock after the write grant. The bench drives every input on the falling edge and samples every output on the falling edge. Its memory and executor models log each granted access and start at the edge where the design acts on them. The checks compare these logs, the memory image and state_o with lists computed from the chain the bench built. They are evaluated only after state_o has settled at suspended, or after a fixed number of clocks for the no-effect cases.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    HS_IDLE   = 2'b00,
    HS_ACTIVE = 2'b01,
    HS_SUSP   = 2'b10
  } host_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_LINK,
    SQ_EXEC_GO,
    SQ_EXEC_WAIT,
    SQ_RD_STAT,
    SQ_WR_STAT,
    SQ_SUSP,
    SQ_CHK
  } seq_state_e;

  // control/status word layout
  localparam int unsigned BIT_DONE = 15;
  localparam int unsigned BIT_OK   = 13;
  localparam int unsigned BIT_SUSP = 30;
  // word offsets inside a block
  localparam int unsigned OFS_LINK = 1;
  localparam int unsigned OFS_PAY  = 2;
endpackage

// File: rtl/cl_mem_port.sv
module cl_mem_port #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic rd_pend_q;

  assign mem_req_o   = cmd_valid_i & ~rd_pend_q;
  assign mem_we_o    = cmd_we_i;
  assign mem_addr_o  = cmd_addr_i;
  assign mem_wdata_o = cmd_wdata_i;
  assign rdata_o     = mem_rdata_i;
  assign done_o      = rd_pend_q | (mem_req_o & mem_gnt_i & cmd_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= 1'b0;
    else         rd_pend_q <= mem_req_o & mem_gnt_i & ~cmd_we_i;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R3
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && !mem_we_o) |=> !mem_req_o);
endmodule

// File: rtl/cl_ptr_regs.sv
module cl_ptr_regs #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          link_we_i,
  input  logic [AW-1:0] link_i,
  input  logic          commit_i,
  output logic [AW-1:0] nxt_o,
  output logic [AW-1:0] last_o
);
  logic [AW-1:0] nxt_q, last_q, link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q  <= '0;
      last_q <= '0;
      link_q <= '0;
    end else begin
      if (link_we_i) link_q <= link_i;
      if (load_start_i) begin
        nxt_q <= start_addr_i;
      end else if (commit_i) begin
        last_q <= nxt_q;
        nxt_q  <= link_q;
      end
    end
  end

  assign nxt_o  = nxt_q;
  assign last_o = last_q;

  // R7
  saved_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_start_i && !commit_i) |=> ($stable(nxt_q) && $stable(last_q)));
endmodule

// File: rtl/cl_seq.sv
module cl_seq
  import cl_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          resume_i,
  output logic [1:0]    state_o,
  output logic          cmd_valid_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o,
  input  logic          cmd_done_i,
  input  logic [DW-1:0] cmd_rdata_i,
  output logic          load_start_o,
  output logic          link_we_o,
  output logic          commit_o,
  input  logic [AW-1:0] nxt_i,
  input  logic [AW-1:0] last_i,
  output logic          exec_start_o,
  output logic [AW-1:0] exec_addr_o,
  input  logic          exec_done_i,
  input  logic          exec_err_i
);
  seq_state_e    st_q, st_d;
  logic          err_q;
  logic [DW-1:0] stat_q;

  always_comb begin
    st_d         = st_q;
    cmd_valid_o  = 1'b0;
    cmd_we_o     = 1'b0;
    cmd_addr_o   = nxt_i;
    load_start_o = 1'b0;
    link_we_o    = 1'b0;
    commit_o     = 1'b0;
    exec_start_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        load_start_o = 1'b1;
        st_d         = SQ_RD_LINK;
      end
      SQ_RD_LINK: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = nxt_i + AW'(OFS_LINK);
        if (cmd_done_i) begin
          link_we_o = 1'b1;
          st_d      = SQ_EXEC_GO;
        end
      end
      SQ_EXEC_GO: begin
        exec_start_o = 1'b1;
        st_d         = SQ_EXEC_WAIT;
      end
      SQ_EXEC_WAIT: if (exec_done_i) st_d = SQ_RD_STAT;
      SQ_RD_STAT: begin
        cmd_valid_o = 1'b1;
        if (cmd_done_i) st_d = SQ_WR_STAT;
      end
      SQ_WR_STAT: begin
        cmd_valid_o = 1'b1;
        cmd_we_o    = 1'b1;
        if (cmd_done_i) begin
          commit_o = 1'b1;
          st_d     = stat_q[BIT_SUSP] ? SQ_SUSP : SQ_RD_LINK;
        end
      end
      SQ_SUSP: begin
        if (start_i) begin
          load_start_o = 1'b1;
          st_d         = SQ_RD_LINK;
        end else if (resume_i) begin
          st_d = SQ_CHK;
        end
      end
      SQ_CHK: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = last_i;
        if (cmd_done_i) st_d = cmd_rdata_i[BIT_SUSP] ? SQ_SUSP : SQ_RD_LINK;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    cmd_wdata_o           = stat_q;
    cmd_wdata_o[BIT_DONE] = 1'b1;
    cmd_wdata_o[BIT_OK]   = ~err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      err_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_EXEC_WAIT && exec_done_i) err_q <= exec_err_i;
      if (st_q == SQ_RD_STAT && cmd_done_i) stat_q <= cmd_rdata_i;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_IDLE: state_o = HS_IDLE;
      SQ_SUSP: state_o = HS_SUSP;
      default: state_o = HS_ACTIVE;
    endcase
  end

  assign exec_addr_o = nxt_i + AW'(OFS_PAY);

  // R11
  state_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);
  // R6
  susp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_SUSP && !start_i && !resume_i) |=> (state_o == HS_SUSP && !cmd_valid_o));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_IDLE && !start_i) |=> state_o == HS_IDLE);
  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_ACTIVE) |-> !load_start_o);
endmodule

// File: rtl/cmd_list_unit.sv
module cmd_list_unit
  import cl_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          resume_i,
  output logic [1:0]    state_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          exec_start_o,
  output logic [AW-1:0] exec_addr_o,
  input  logic          exec_done_i,
  input  logic          exec_err_i
);
  logic          cmd_valid, cmd_we, cmd_done;
  logic [AW-1:0] cmd_addr, nxt, last;
  logic [DW-1:0] cmd_wdata, cmd_rdata;
  logic          load_start, link_we, commit;

  cl_mem_port #(.AW(AW), .DW(DW)) i_port (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .done_o(cmd_done), .rdata_o(cmd_rdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rdata_i
  );

  cl_ptr_regs #(.AW(AW)) i_ptrs (
    .clk_i, .rst_ni,
    .load_start_i(load_start), .start_addr_i,
    .link_we_i(link_we), .link_i(cmd_rdata[AW-1:0]),
    .commit_i(commit), .nxt_o(nxt), .last_o(last)
  );

  cl_seq #(.AW(AW), .DW(DW)) i_seq (
    .clk_i, .rst_ni, .start_i, .resume_i, .state_o,
    .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .cmd_wdata_o(cmd_wdata), .cmd_done_i(cmd_done), .cmd_rdata_i(cmd_rdata),
    .load_start_o(load_start), .link_we_o(link_we), .commit_o(commit),
    .nxt_i(nxt), .last_i(last),
    .exec_start_o, .exec_addr_o, .exec_done_i, .exec_err_i
  );

  // port-level tracking of the last granted read for the write-back check
  logic          rd_seen_q;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] rd_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_seen_q <= 1'b0;
      rd_addr_q <= '0;
      rd_word_q <= '0;
    end else begin
      rd_seen_q <= mem_req_o & mem_gnt_i & ~mem_we_o;
      if (mem_req_o && mem_gnt_i && !mem_we_o) rd_addr_q <= mem_addr_o;
      if (rd_seen_q) rd_word_q <= mem_rdata_i;
    end
  end

  // R4
  wb_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == rd_addr_q));
  // R4
  wb_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !rd_seen_q) |->
      (mem_wdata_o[BIT_DONE] &&
       ((mem_wdata_o ^ rd_word_q) & ~((DW'(1) << BIT_DONE) | (DW'(1) << BIT_OK))) == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (state_o != HS_IDLE));
endmodule

// File: tb/test_cmd_list_unit.sv
module test_cmd_list_unit;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          resume_i = 1'b0;
  logic [1:0]    state_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_gnt_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          exec_start_o;
  logic [AW-1:0] exec_addr_o;
  logic          exec_done_i = 1'b0;
  logic          exec_err_i = 1'b0;

  always #2 clk = ~clk;

  cmd_list_unit #(.AW(AW), .DW(DW)) i_cmd_list_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .start_addr_i, .resume_i, .state_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rdata_i,
    .exec_start_o, .exec_addr_o, .exec_done_i, .exec_err_i
  );

  int vecs = 0;
  int fails = 0;

  logic [DW-1:0] mem [256];
  int            acc_n = 0;
  logic          acc_we [4096];
  logic [AW-1:0] acc_addr [4096];
  int            ex_n = 0;
  logic [AW-1:0] ex_addr [512];
  logic          ex_err [512];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random grant, access takes effect at the grant edge
  initial begin : mem_model
    logic p_v, p_we;
    logic [AW-1:0] p_a;
    logic [DW-1:0] p_d;
    p_v = 1'b0; p_we = 1'b0; p_a = '0; p_d = '0;
    forever begin
      @(negedge clk);
      if (p_v) begin
        if (p_we) mem[p_a] = p_d;
        else      mem_rdata_i = mem[p_a];
        if (acc_n < 4096) begin
          acc_we[acc_n] = p_we;
          acc_addr[acc_n] = p_a;
          acc_n++;
        end
      end
      mem_gnt_i = mem_req_o && ($urandom % 3 != 0);
      p_v  = mem_gnt_i && mem_req_o;
      p_we = mem_we_o;
      p_a  = mem_addr_o;
      p_d  = mem_wdata_o;
    end
  end

  // executor model
  initial begin : exec_model
    int cnt;
    logic e;
    cnt = 0; e = 1'b0;
    forever begin
      @(negedge clk);
      exec_done_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          exec_done_i = 1'b1;
          exec_err_i  = e;
        end
      end
      if (exec_start_o) begin
        e = ($urandom % 4 == 0);
        if (ex_n < 512) begin
          ex_addr[ex_n] = exec_addr_o;
          ex_err[ex_n]  = e;
          ex_n++;
        end
        cnt = 1 + $urandom % 4;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  task automatic pulse_start(input logic [AW-1:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_resume();
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
  endtask

  task automatic wait_susp();
    int n = 0;
    repeat (2) @(negedge clk);
    while (state_o != 2'b10 && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // expected chain
  logic [AW-1:0] blk [4];
  logic [DW-1:0] orig [4];
  int            len;

  task automatic build_chain(input int half, input int s0, input logic [AW-1:0] tail_link);
    int stride = 1 + 2 * ($urandom % 8);
    len = 1 + $urandom % 4;
    for (int j = 0; j < len; j++)
      blk[j] = AW'((half * 16 + (s0 + j * stride) % 16) * 8);
    for (int j = 0; j < len; j++) begin
      orig[j] = $urandom;
      orig[j][30] = (j == len - 1);
      mem[blk[j]] = orig[j];
      mem[blk[j] + 1] = (j == len - 1) ? DW'(tail_link) : DW'(blk[j + 1]);
    end
  endtask

  task automatic check_chain(input int ex_base, input string tag);
    chk({tag, " R6 suspended"}, 32'(state_o), 32'h2);
    chk({tag, " R5 exec count"}, ex_n - ex_base, len);
    for (int j = 0; j < len; j++) begin
      logic [DW-1:0] w;
      w = orig[j] & ~32'h0000_A000;
      w[15] = 1'b1;
      if (ex_base + j < ex_n) begin
        chk({tag, " R2 exec addr"}, 32'(ex_addr[ex_base + j]), 32'(blk[j] + 2));
        w[13] = ~ex_err[ex_base + j];
      end
      chk({tag, " R4 status word"}, mem[blk[j]], w);
    end
  endtask

  initial begin : main
    logic [AW-1:0] prev_tail, head;
    int half, s0, nxt_s0, eb, ab;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 state", 32'(state_o), 32'h0);
    chk("R1 req", 32'(mem_req_o), 32'h0);
    chk("R1 exec_start", 32'(exec_start_o), 32'h0);

    // R9 resume in idle
    pulse_resume();
    repeat (3) @(negedge clk);
    chk("R9 idle resume state", 32'(state_o), 32'h0);
    chk("R9 idle resume req", 32'(mem_req_o), 32'h0);

    // first chain, with start/resume injected while active
    s0 = $urandom % 16;
    nxt_s0 = $urandom % 16;
    build_chain(0, s0, AW'((16 + nxt_s0) * 8));
    head = blk[0];
    prev_tail = blk[len - 1];
    eb = ex_n;
    ab = acc_n;
    pulse_start(head);
    chk("R11 active code", 32'(state_o), 32'h1);
    pulse_resume();                 // R9 active
    pulse_start(AW'(8 * 9 + 4));    // R10 active
    chk("R10 still active", 32'(state_o), 32'h1);
    wait_susp();
    chk("R2 first access we", 32'(acc_we[ab]), 32'h0);
    chk("R2 first access addr", 32'(acc_addr[ab]), 32'(head + 1));
    check_chain(eb, "R10 chain0");
    repeat (5) @(negedge clk);
    chk("R6 no req while suspended", 32'(mem_req_o), 32'h0);
    chk("R6 no new exec", ex_n - eb, len);

    for (int it = 1; it < 40; it++) begin
      logic use_resume;
      half = it % 2;
      s0 = nxt_s0;
      nxt_s0 = $urandom % 16;
      build_chain(half, s0, AW'(((1 - half) * 16 + nxt_s0) * 8));
      head = blk[0];
      use_resume = ($urandom % 2 == 1);
      if (use_resume) begin
        if (it % 3 == 0) begin
          // R8: suspend bit still set on re-read
          ab = acc_n;
          eb = ex_n;
          pulse_resume();
          repeat (12) @(negedge clk);
          chk("R8 back to suspended", 32'(state_o), 32'h2);
          chk("R8 single access", acc_n - ab, 1);
          chk("R8 reread addr", 32'(acc_addr[ab]), 32'(prev_tail));
          chk("R8 no exec", ex_n - eb, 0);
        end
        mem[prev_tail][30] = 1'b0;
        mem[prev_tail + 1] = 32'(AW'(8 * ((s0 + 5) % 16) + 3));  // stale link must be ignored
        ab = acc_n;
        eb = ex_n;
        pulse_resume();
        wait_susp();
        chk("R7 reread is read", 32'(acc_we[ab]), 32'h0);
        chk("R7 reread addr", 32'(acc_addr[ab]), 32'(prev_tail));
        chk("R7 next access addr", 32'(acc_addr[ab + 1]), 32'(head + 1));
        check_chain(eb, "R7 resumed");
      end else begin
        ab = acc_n;
        eb = ex_n;
        pulse_start(head);
        chk("R11 active after start", 32'(state_o), 32'h1);
        wait_susp();
        chk("R2 link read addr", 32'(acc_addr[ab]), 32'(head + 1));
        check_chain(eb, "R5 started");
      end
      prev_tail = blk[len - 1];
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule